// File: doc/BRIEF.md
# Matrix-Multiply Coprocessor Parameter Shell

This block sits between a host processor and a matrix-multiply engine. The host fills a small bank of 32-bit exchange registers with the operation's parameters. These are the three matrix dimensions, the base address and leading stride of each of the three matrices, and two 64-bit double-precision scale factors, each split into a high word and a low word. The host then pulses an execute strobe. The shell copies the whole bank into a shadow set that drives the engine. It reduces the two scale factors to single control bits, starts the engine, and reports completion through an end signal that the host polls.

The engine handles only a scale of plus or minus one on the product and a scale of zero or one on the prior result. The shell therefore checks both 64-bit patterns during the copy. If either pattern is unsupported, it skips the engine entirely, finishes at once and raises an error flag. While an operation is in flight, the bank is locked against writes and further execute strobes are dropped, so the engine always sees the parameters that were present when it was started.

Top module: `mm_param_shell`

## Requirements
- R1: After reset, the end signal, the error flag, the start pulse and every parameter output are 0.
- R2: Exchange register indices carry, in order: 0 rows (m), 1 columns (n), 2 inner depth (k), 3 product-scale high word, 4 product-scale low word, 5 A base, 6 A stride, 7 B base, 8 B stride, 9 result-scale high word, 10 result-scale low word, 11 C base, 12 C stride. At the start pulse, each parameter output equals the value last written to its index.
- R3: Product scale 0x3FF00000_00000000 (+1.0) gives negate = 0, and 0xBFF00000_00000000 (-1.0) gives negate = 1.
- R4: Result scale 0x00000000_00000000 (0.0) gives keep_c = 0, and 0x3FF00000_00000000 (1.0) gives keep_c = 1.
- R5: Any other product-scale or result-scale pattern makes the shell finish without a start pulse. The end signal and the error flag both go high two cycles after the execute strobe is sampled.
- R6: With valid scales, the start pulse is high for exactly one cycle, two cycles after the execute strobe is sampled. The copy phase between the strobe and the start pulse lasts exactly one cycle.
- R7: The end signal rises one cycle after the done input is sampled during a run. It stays high until the next execute strobe is sampled, and falls in the cycle after that strobe.
- R8: Writes during the copy phase or a run, and writes to indices 13 to 15, leave the bank unchanged.
- R9: An execute strobe during the copy phase or a run is dropped and produces no further start pulse.
- R10: A register write in the same cycle as an accepted execute strobe is included in the copied parameters.
- R11: The parameter outputs change only at a copy phase. Writes made after completion do not alter them until the next execute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Exchange register write strobe |
| wr_idx | input | 4 | Exchange register index |
| wr_data | input | 32 | Exchange register write data |
| exec_req | input | 1 | Execute strobe from the host |
| end_flag | output | 1 | Operation finished; held until the next execute |
| cfg_error | output | 1 | Unsupported scale pattern on the last operation |
| core_start | output | 1 | One-cycle start pulse to the engine |
| core_done | input | 1 | Engine completion strobe |
| core_rows | output | 32 | Rows of A and C (m) |
| core_cols | output | 32 | Columns of B and C (n) |
| core_depth | output | 32 | Inner dimension (k) |
| core_a_base | output | 32 | Base address of A |
| core_a_stride | output | 32 | Leading stride of A |
| core_b_base | output | 32 | Base address of B |
| core_b_stride | output | 32 | Leading stride of B |
| core_c_base | output | 32 | Base address of C |
| core_c_stride | output | 32 | Leading stride of C |
| core_negate | output | 1 | Product is subtracted instead of added |
| core_keep_c | output | 1 | Prior C contents are accumulated onto |

## Verification
Two functions can fall in the same cycle: a bank write and the execute strobe that copies the bank. The bench drives both at once, with a fresh value to one index, and requires that value to appear on the matching parameter output at the start pulse. It also places the engine's done strobe in the very cycle of the start pulse, and an execute strobe in the middle of a run. The first must give a one-cycle run. The second must give neither a second start nor an early end.

// File: rtl/mm_param_pkg.sv
package mm_param_pkg;

    localparam int WORD_W    = 32;
    localparam int XREG_N    = 13;
    localparam int XIDX_W    = $clog2(XREG_N + 3);

    localparam int IX_ROWS   = 0;
    localparam int IX_COLS   = 1;
    localparam int IX_DEPTH  = 2;
    localparam int IX_AL_HI  = 3;
    localparam int IX_AL_LO  = 4;
    localparam int IX_ABASE  = 5;
    localparam int IX_ASTR   = 6;
    localparam int IX_BBASE  = 7;
    localparam int IX_BSTR   = 8;
    localparam int IX_BE_HI  = 9;
    localparam int IX_BE_LO  = 10;
    localparam int IX_CBASE  = 11;
    localparam int IX_CSTR   = 12;

    localparam logic [63:0] FP_POS_ONE = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] FP_NEG_ONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] FP_ZERO    = 64'h0000_0000_0000_0000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rows;
        logic [WORD_W-1:0] cols;
        logic [WORD_W-1:0] depth;
        logic [WORD_W-1:0] a_base;
        logic [WORD_W-1:0] a_stride;
        logic [WORD_W-1:0] b_base;
        logic [WORD_W-1:0] b_stride;
        logic [WORD_W-1:0] c_base;
        logic [WORD_W-1:0] c_stride;
        logic              negate;
        logic              keep_c;
    } mm_cfg_t;

    typedef struct packed {
        logic ok;
        logic bit_out;
    } scale_dec_t;

    function automatic scale_dec_t decode_alpha(input logic [63:0] v);
        scale_dec_t r;
        r.ok      = (v == FP_POS_ONE) || (v == FP_NEG_ONE);
        r.bit_out = (v == FP_NEG_ONE);
        return r;
    endfunction

    function automatic scale_dec_t decode_beta(input logic [63:0] v);
        scale_dec_t r;
        r.ok      = (v == FP_ZERO) || (v == FP_POS_ONE);
        r.bit_out = (v == FP_POS_ONE);
        return r;
    endfunction

endpackage

// File: rtl/xreg_bank.sv
module xreg_bank
    import mm_param_pkg::*;
#(
    parameter int N     = XREG_N,
    parameter int W     = WORD_W,
    parameter int IDX_W = XIDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lock,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] regs
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && !lock && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    AST_BANK_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(regs)) else $error("bank changed while locked"); // R8

endmodule

// File: rtl/scale_check.sv
module scale_check
    import mm_param_pkg::*;
#(
    parameter int N = XREG_N,
    parameter int W = WORD_W
) (
    input  logic [N-1:0][W-1:0] regs,
    output mm_cfg_t             cfg,
    output logic                cfg_ok
);

    scale_dec_t al_d;
    scale_dec_t be_d;

    always_comb begin
        al_d = decode_alpha({regs[IX_AL_HI], regs[IX_AL_LO]});
        be_d = decode_beta({regs[IX_BE_HI], regs[IX_BE_LO]});

        cfg.rows     = regs[IX_ROWS];
        cfg.cols     = regs[IX_COLS];
        cfg.depth    = regs[IX_DEPTH];
        cfg.a_base   = regs[IX_ABASE];
        cfg.a_stride = regs[IX_ASTR];
        cfg.b_base   = regs[IX_BBASE];
        cfg.b_stride = regs[IX_BSTR];
        cfg.c_base   = regs[IX_CBASE];
        cfg.c_stride = regs[IX_CSTR];
        cfg.negate   = al_d.bit_out;
        cfg.keep_c   = be_d.bit_out;
        cfg_ok       = al_d.ok && be_d.ok;
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import mm_param_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       exec_req,
    input  logic       core_done,
    input  logic       cfg_ok,
    output seq_state_t state,
    output logic       load_en,
    output logic       busy,
    output logic       core_start,
    output logic       end_flag,
    output logic       cfg_error
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            core_start <= 1'b0;
            cfg_error  <= 1'b0;
        end else begin
            core_start <= 1'b0;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (exec_req) begin
                        state     <= ST_LATCH;
                        cfg_error <= 1'b0;
                    end
                end
                ST_LATCH: begin
                    if (cfg_ok) begin
                        state      <= ST_RUN;
                        core_start <= 1'b1;
                    end else begin
                        state     <= ST_DONE;
                        cfg_error <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (core_done) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign load_en  = (state == ST_LATCH);
    assign busy     = (state == ST_LATCH) || (state == ST_RUN);
    assign end_flag = (state == ST_DONE);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start) else $error("start longer than one cycle"); // R6
    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) |=> (state != ST_LATCH)) else $error("copy phase too long"); // R6
    AST_END_HELD: assert property (@(posedge clk) disable iff (rst)
        (end_flag && !exec_req) |=> end_flag) else $error("end dropped early"); // R7
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> !core_start) else $error("start with error"); // R5
    AST_EXEC_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> !core_start) else $error("restart during run"); // R9

endmodule

// File: rtl/mm_param_shell.sv
module mm_param_shell
    import mm_param_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [XIDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                exec_req,
    output logic                end_flag,
    output logic                cfg_error,
    output logic                core_start,
    input  logic                core_done,
    output logic [WORD_W-1:0]   core_rows,
    output logic [WORD_W-1:0]   core_cols,
    output logic [WORD_W-1:0]   core_depth,
    output logic [WORD_W-1:0]   core_a_base,
    output logic [WORD_W-1:0]   core_a_stride,
    output logic [WORD_W-1:0]   core_b_base,
    output logic [WORD_W-1:0]   core_b_stride,
    output logic [WORD_W-1:0]   core_c_base,
    output logic [WORD_W-1:0]   core_c_stride,
    output logic                core_negate,
    output logic                core_keep_c
);

    logic [XREG_N-1:0][WORD_W-1:0] bank;
    mm_cfg_t    live_cfg;
    mm_cfg_t    shadow;
    logic       cfg_ok;
    logic       load_en;
    logic       busy;
    seq_state_t state;

    xreg_bank #(.N(XREG_N), .W(WORD_W), .IDX_W(XIDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .lock    (busy),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs    (bank)
    );

    scale_check #(.N(XREG_N), .W(WORD_W)) u_check (
        .regs   (bank),
        .cfg    (live_cfg),
        .cfg_ok (cfg_ok)
    );

    seq_ctrl u_seq (
        .clk        (clk),
        .rst        (rst),
        .exec_req   (exec_req),
        .core_done  (core_done),
        .cfg_ok     (cfg_ok),
        .state      (state),
        .load_en    (load_en),
        .busy       (busy),
        .core_start (core_start),
        .end_flag   (end_flag),
        .cfg_error  (cfg_error)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (load_en) begin
            shadow <= live_cfg;
        end
    end

    assign core_rows     = shadow.rows;
    assign core_cols     = shadow.cols;
    assign core_depth    = shadow.depth;
    assign core_a_base   = shadow.a_base;
    assign core_a_stride = shadow.a_stride;
    assign core_b_base   = shadow.b_base;
    assign core_b_stride = shadow.b_stride;
    assign core_c_base   = shadow.c_base;
    assign core_c_stride = shadow.c_stride;
    assign core_negate   = shadow.negate;
    assign core_keep_c   = shadow.keep_c;

    AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LATCH) |=> $stable(shadow)) else $error("params moved outside copy"); // R11
    AST_START_AFTER_COPY: assert property (@(posedge clk) disable iff (rst)
        core_start |-> $past(load_en)) else $error("start without copy"); // R6

endmodule

// File: tb/tb_mm_param_shell.sv
`timescale 1ns/1ps
module tb_mm_param_shell;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        exec_req = 1'b0;
    logic        core_done = 1'b0;
    logic        end_flag, cfg_error, core_start, core_negate, core_keep_c;
    logic [31:0] core_rows, core_cols, core_depth, core_a_base, core_a_stride;
    logic [31:0] core_b_base, core_b_stride, core_c_base, core_c_stride;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [13];

    always #2 clk = ~clk;

    mm_param_shell dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exec_req(exec_req), .end_flag(end_flag), .cfg_error(cfg_error),
        .core_start(core_start), .core_done(core_done),
        .core_rows(core_rows), .core_cols(core_cols), .core_depth(core_depth),
        .core_a_base(core_a_base), .core_a_stride(core_a_stride),
        .core_b_base(core_b_base), .core_b_stride(core_b_stride),
        .core_c_base(core_c_base), .core_c_stride(core_c_stride),
        .core_negate(core_negate), .core_keep_c(core_keep_c)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit alpha_ok(input logic [31:0] hi, input logic [31:0] lo);
        return ({hi, lo} == 64'h3FF0000000000000) || ({hi, lo} == 64'hBFF0000000000000);
    endfunction
    function automatic bit beta_ok(input logic [31:0] hi, input logic [31:0] lo);
        return ({hi, lo} == 64'h0) || ({hi, lo} == 64'h3FF0000000000000);
    endfunction

    task automatic wr(input int idx, input logic [31:0] d, input bit accepted);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (accepted && idx < 13) model[idx] = d;
    endtask

    task automatic check_params(input string tag);
        chk(core_rows == model[0], {tag, " R2 rows"}, core_rows, model[0]);
        chk(core_cols == model[1], {tag, " R2 cols"}, core_cols, model[1]);
        chk(core_depth == model[2], {tag, " R2 depth"}, core_depth, model[2]);
        chk(core_a_base == model[5], {tag, " R2 a_base"}, core_a_base, model[5]);
        chk(core_a_stride == model[6], {tag, " R2 a_stride"}, core_a_stride, model[6]);
        chk(core_b_base == model[7], {tag, " R2 b_base"}, core_b_base, model[7]);
        chk(core_b_stride == model[8], {tag, " R2 b_stride"}, core_b_stride, model[8]);
        chk(core_c_base == model[11], {tag, " R2 c_base"}, core_c_base, model[11]);
        chk(core_c_stride == model[12], {tag, " R2 c_stride"}, core_c_stride, model[12]);
        chk(core_negate == (model[3][31]), {tag, " R3 negate"}, core_negate, model[3][31]);
        chk(core_keep_c == (model[9] == 32'h3FF00000), {tag, " R4 keep_c"},
            core_keep_c, (model[9] == 32'h3FF00000));
    endtask

    // Runs one operation. sim_idx >= 0 writes that index in the execute cycle (R10).
    // done_wait: cycles of run before done; 0 = done in start cycle.
    // busy_poke: write and re-execute during the run (R8, R9).
    task automatic run_op(input int sim_idx, input logic [31:0] sim_val,
                          input int done_wait, input bit busy_poke);
        bit valid;
        @(negedge clk);
        exec_req = 1'b1;
        if (sim_idx >= 0) begin
            wr_en = 1'b1; wr_idx = 4'(sim_idx); wr_data = sim_val;
            model[sim_idx] = sim_val;
        end
        @(negedge clk);
        exec_req = 1'b0; wr_en = 1'b0;
        valid = alpha_ok(model[3], model[4]) && beta_ok(model[9], model[10]);
        chk(end_flag == 1'b0, "R7 end cleared after execute", end_flag, 0);
        chk(core_start == 1'b0, "R6 no start in copy phase", core_start, 0);
        // copy phase: write here must be ignored (R8)
        wr_en = 1'b1; wr_idx = 4'd1; wr_data = $urandom;
        @(negedge clk);
        wr_en = 1'b0;
        if (!valid) begin
            chk(end_flag == 1'b1, "R5 end after bad scale", end_flag, 1);
            chk(cfg_error == 1'b1, "R5 error flag", cfg_error, 1);
            chk(core_start == 1'b0, "R5 no start", core_start, 0);
            return;
        end
        chk(core_start == 1'b1, "R6 start pulse", core_start, 1);
        chk(cfg_error == 1'b0, "R5 no error on valid", cfg_error, 0);
        check_params("start");
        if (done_wait == 0) begin
            core_done = 1'b1;
            @(negedge clk);
            core_done = 1'b0;
            chk(core_start == 1'b0, "R6 start one cycle", core_start, 0);
        end else begin
            @(negedge clk);
            chk(core_start == 1'b0, "R6 start one cycle", core_start, 0);
            if (busy_poke) begin
                wr(0, $urandom, 1'b0);
                @(negedge clk);
                exec_req = 1'b1;
                @(negedge clk);
                exec_req = 1'b0;
                chk(core_start == 1'b0, "R9 execute during run dropped", core_start, 0);
                chk(end_flag == 1'b0, "R9 no early end", end_flag, 0);
            end
            for (int i = 0; i < done_wait; i++) begin
                @(negedge clk);
                chk(end_flag == 1'b0 && core_start == 1'b0, "R7 end low while running",
                    {end_flag, core_start}, 0);
            end
            core_done = 1'b1;
            @(negedge clk);
            core_done = 1'b0;
        end
        chk(end_flag == 1'b1, "R7 end after done", end_flag, 1);
        @(negedge clk);
        @(negedge clk);
        chk(end_flag == 1'b1, "R7 end held", end_flag, 1);
        check_params("after done R11");
    endtask

    task automatic load_all(input bit good);
        for (int i = 0; i < 13; i++) begin
            logic [31:0] v;
            v = $urandom;
            if (i == 3) v = ($urandom % 2) ? 32'hBFF00000 : 32'h3FF00000;
            if (i == 4 || i == 10) v = 32'h0;
            if (i == 9) v = ($urandom % 2) ? 32'h3FF00000 : 32'h0;
            wr(i, v, 1'b1);
        end
        if (!good) begin
            if ($urandom % 2) wr(3, 32'h40000000, 1'b1);
            else wr(10, 32'h00000001, 1'b1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        for (int i = 0; i < 13; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(end_flag == 0 && cfg_error == 0 && core_start == 0, "R1 reset flags",
            {end_flag, cfg_error, core_start}, 0);
        chk(core_rows == 0 && core_c_stride == 0 && core_negate == 0, "R1 reset params",
            core_rows, 0);

        // directed: +1 / 0
        load_all(1'b1);
        wr(3, 32'h3FF00000, 1'b1); wr(9, 32'h0, 1'b1);
        run_op(-1, 0, 3, 1'b0);
        chk(core_negate == 0 && core_keep_c == 0, "R3 R4 plus one / zero",
            {core_negate, core_keep_c}, 0);

        // directed: -1 / 1, done in start cycle
        wr(3, 32'hBFF00000, 1'b1); wr(9, 32'h3FF00000, 1'b1);
        run_op(-1, 0, 0, 1'b0);
        chk(core_negate == 1 && core_keep_c == 1, "R3 R4 minus one / one",
            {core_negate, core_keep_c}, 2'b11);

        // R11: write after completion, outputs stay put
        wr(0, 32'hDEAD0001, 1'b1);
        @(negedge clk);
        chk(core_rows != 32'hDEAD0001 && end_flag == 1, "R11 outputs frozen after write",
            core_rows, 0);

        // R8: out-of-range index
        wr(14, 32'hFFFFFFFF, 1'b0);
        wr(13, 32'hFFFFFFFF, 1'b0);

        // R10 simultaneous write and execute, with busy pokes (R8, R9)
        run_op(2, 32'h0000BEEF, 4, 1'b1);
        chk(core_depth == 32'h0000BEEF, "R10 same-cycle write latched", core_depth, 32'hBEEF);

        // R5 invalid patterns
        wr(3, 32'h40000000, 1'b1);
        run_op(-1, 0, 1, 1'b0);
        @(negedge clk);
        chk(end_flag == 1 && cfg_error == 1 && core_start == 0, "R5 bad alpha hold",
            {end_flag, cfg_error, core_start}, 3'b110);
        wr(3, 32'h3FF00000, 1'b1); wr(10, 32'h00000001, 1'b1);
        run_op(-1, 0, 1, 1'b0);
        wr(10, 32'h0, 1'b1);
        run_op(-1, 0, 2, 1'b0);
        chk(cfg_error == 0, "R5 error cleared by next good run", cfg_error, 0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            bit good;
            good = ($urandom % 5) != 0;
            load_all(good);
            run_op((($urandom % 3) == 0) ? int'($urandom % 13) : -1, $urandom,
                   int'($urandom % 6), ($urandom % 2) == 1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule